// File: doc/BRIEF.md
# Auxiliary Video Information Packet Builder

This block assembles the 17-byte auxiliary video information packet that a display transmitter sends to a sink. From the mode it is given, it derives the colorimetry flag (standard or high definition) and the picture aspect code (4:3 or 16:9). It computes the checksum that makes the whole packet sum to zero, then hands the bytes one at a time to a downstream packet buffer under a valid/ready handshake.

A single-cycle `start` pulse captures the pixel clock (in kHz) and the active width and height. The block first divides a scaled width by the height with a bit-serial divider. It then walks the packet once to accumulate the checksum, and walks it a second time to stream the bytes in index order. A one-cycle `outDone` pulse marks the end. Packet scheduling and line encoding are left to other blocks.

Top module: `avi_frame_gen`

## Requirements
- R1: After reset, `outValid` and `outDone` are low and stay low until a packet is started.
- R2: Byte index 0 carries 0x82, index 1 carries 0x02, index 2 carries 0x0D, index 4 carries 0x12 and index 6 carries 0x88; indices 7 through 16 carry 0x00.
- R3: Bits 7:6 of byte index 5 are 01 (value 0x40) when the captured pixel clock is at most 27000 kHz, and 10 (value 0x80) when it is above.
- R4: Bits 5:3 of byte index 5 are 011 (0x18) when floor(width*100/height) is below 156, and 101 (0x28) otherwise.
- R5: A captured height of zero selects the 0x28 aspect code in byte index 5, without dividing.
- R6: Byte index 3 is the checksum: the 8-bit sum of all 17 streamed bytes is 0x00.
- R7: Bytes are streamed in index order 0 to 16, with `outIdx` giving the index of the byte on `outByte`; a stream starts at index 0.
- R8: A byte is accepted only on a cycle where `outValid` and `outReady` are both high; while `outValid` is high and `outReady` is low, `outByte`, `outIdx` and `outValid` hold.
- R9: `outDone` is high for exactly one cycle, the cycle after index 16 is accepted, and `outValid` is low during it.
- R10: Mode inputs are captured only by a `start` seen while idle; a `start` pulse or a change of the mode inputs during a packet has no effect on the packet and starts no second packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet with the current mode inputs (honoured when idle) |
| pixClkKhz | input | CLK_W (20) | Pixel clock in kHz |
| hRes | input | DIM_W (12) | Active width in pixels |
| vRes | input | DIM_W (12) | Active height in lines |
| outReady | input | 1 | Downstream buffer accepts a byte |
| outByte | output | 8 | Packet byte |
| outIdx | output | 5 | Index of the byte on `outByte` |
| outValid | output | 1 | `outByte` holds a packet byte |
| outDone | output | 1 | One-cycle pulse after the final byte is accepted |

## Verification
On every cycle, the assertions check the handshake side of the block. A byte held under back-pressure stays stable, indices advance by exactly one per accepted byte and start at zero, the first header byte is fixed, the colorimetry field is one-hot, and `outDone` is a lone pulse that follows acceptance of the last index. The bench's sweeps are needed for the values that depend on the mode. It covers the pixel clock on both sides of the 27000 kHz limit, aspect ratios on both sides of the 156 threshold including the exact boundary, a zero height, the checksum, and mode inputs that change or restart pulses that arrive in the middle of a packet.

// File: rtl/avi_pkg.sv
package avi_pkg;

  localparam int PKT_LEN = 17;
  localparam int IDX_W   = $clog2(PKT_LEN);

  typedef enum logic [2:0] {
    AV_IDLE,
    AV_DIV,
    AV_SUM,
    AV_SEND,
    AV_FIN
  } avi_state_e;

  typedef struct packed {
    logic ld;
    logic divStep;
    logic accStep;
    logic idxInc;
    logic idxClr;
  } avi_strobe_t;

  // Constant bytes of the packet; slots that depend on the mode read as zero.
  function automatic logic [7:0] fixedByte(input logic [IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      IDX_W'(0): b = 8'h82;
      IDX_W'(1): b = 8'h02;
      IDX_W'(2): b = 8'h0D;
      IDX_W'(4): b = 8'h12;
      IDX_W'(6): b = 8'h88;
      default:   b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/avi_ctrl.sv
module avi_ctrl
  import avi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        outReady,
  input  logic        divLast,
  input  logic        vZero,
  input  logic        idxLast,
  output avi_strobe_t stb,
  output logic        outValid,
  output logic        outDone
);

  avi_state_e st, stNx;

  always_ff @(posedge clk) begin
    if (!rstN) st <= AV_IDLE;
    else       st <= stNx;
  end

  always_comb begin
    stNx = st;
    stb  = '0;
    case (st)
      AV_IDLE: begin
        if (start) begin
          stb.ld = 1'b1;
          stNx   = AV_DIV;
        end
      end
      AV_DIV: begin
        if (vZero) begin
          stNx = AV_SUM;
        end else begin
          stb.divStep = 1'b1;
          if (divLast) stNx = AV_SUM;
        end
      end
      AV_SUM: begin
        stb.accStep = 1'b1;
        if (idxLast) begin
          stb.idxClr = 1'b1;
          stNx       = AV_SEND;
        end else begin
          stb.idxInc = 1'b1;
        end
      end
      AV_SEND: begin
        if (outReady) begin
          if (idxLast) begin
            stb.idxClr = 1'b1;
            stNx       = AV_FIN;
          end else begin
            stb.idxInc = 1'b1;
          end
        end
      end
      AV_FIN:  stNx = AV_IDLE;
      default: stNx = AV_IDLE;
    endcase
  end

  assign outValid = (st == AV_SEND);
  assign outDone  = (st == AV_FIN);

endmodule

// File: rtl/avi_dp.sv
module avi_dp
  import avi_pkg::*;
#(
  parameter int CLK_W        = 20,
  parameter int DIM_W        = 12,
  parameter int SD_LIMIT_KHZ = 27000,
  parameter int RATIO_SPLIT  = 156
) (
  input  logic             clk,
  input  logic             rstN,
  input  avi_strobe_t      stb,
  input  logic [CLK_W-1:0] pixClkKhz,
  input  logic [DIM_W-1:0] hRes,
  input  logic [DIM_W-1:0] vRes,
  output logic             divLast,
  output logic             vZero,
  output logic             idxLast,
  output logic [7:0]       outByte,
  output logic [IDX_W-1:0] outIdx
);

  localparam int NUM_W = DIM_W + 7;
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num;
  logic [DIM_W-1:0] rem;
  logic [DIM_W-1:0] divisor;
  logic [CNT_W-1:0] divCnt;
  logic             hdSel;
  logic [IDX_W-1:0] idx;
  logic [7:0]       acc;

  logic [DIM_W:0]   remSh;
  logic             remGe;
  logic [DIM_W:0]   remSub;
  logic             narrow;
  logic [7:0]       modeByte;
  logic [7:0]       sumByte;

  assign remSh  = {rem, num[NUM_W-1]};
  assign remGe  = (remSh >= {1'b0, divisor});
  assign remSub = remSh - {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      num     <= '0;
      rem     <= '0;
      divisor <= '0;
      divCnt  <= '0;
      hdSel   <= 1'b0;
      vZero   <= 1'b0;
    end else if (stb.ld) begin
      num     <= NUM_W'(hRes) * NUM_W'(100);
      rem     <= '0;
      divisor <= vRes;
      divCnt  <= '0;
      hdSel   <= (pixClkKhz > CLK_W'(SD_LIMIT_KHZ));
      vZero   <= (vRes == '0);
    end else if (stb.divStep) begin
      num    <= {num[NUM_W-2:0], remGe};
      rem    <= remGe ? remSub[DIM_W-1:0] : remSh[DIM_W-1:0];
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  assign divLast = (divCnt == CNT_W'(NUM_W - 1));

  // After the divide, num holds the quotient.
  assign narrow   = !vZero && (num < NUM_W'(RATIO_SPLIT));
  assign modeByte = (hdSel ? 8'h80 : 8'h40) | (narrow ? 8'h18 : 8'h28);

  always_comb begin
    sumByte = fixedByte(idx);
    if (idx == IDX_W'(5)) sumByte = modeByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0;
      acc <= '0;
    end else begin
      if (stb.ld) acc <= '0;
      else if (stb.accStep) acc <= acc + sumByte;

      if (stb.ld || stb.idxClr) idx <= '0;
      else if (stb.idxInc) idx <= idx + IDX_W'(1);
    end
  end

  assign idxLast = (idx == IDX_W'(PKT_LEN - 1));
  assign outIdx  = idx;
  assign outByte = (idx == IDX_W'(3)) ? (8'h00 - acc) : sumByte;

endmodule

// File: rtl/avi_frame_gen.sv
module avi_frame_gen
  import avi_pkg::*;
#(
  parameter int CLK_W        = 20,
  parameter int DIM_W        = 12,
  parameter int SD_LIMIT_KHZ = 27000,
  parameter int RATIO_SPLIT  = 156
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CLK_W-1:0] pixClkKhz,
  input  logic [DIM_W-1:0] hRes,
  input  logic [DIM_W-1:0] vRes,
  input  logic             outReady,
  output logic [7:0]       outByte,
  output logic [4:0]       outIdx,
  output logic             outValid,
  output logic             outDone
);

  avi_strobe_t stb;
  logic        divLast;
  logic        vZero;
  logic        idxLast;
  logic [IDX_W-1:0] idxW;

  avi_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .outReady (outReady),
    .divLast  (divLast),
    .vZero    (vZero),
    .idxLast  (idxLast),
    .stb      (stb),
    .outValid (outValid),
    .outDone  (outDone)
  );

  avi_dp #(
    .CLK_W        (CLK_W),
    .DIM_W        (DIM_W),
    .SD_LIMIT_KHZ (SD_LIMIT_KHZ),
    .RATIO_SPLIT  (RATIO_SPLIT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pixClkKhz (pixClkKhz),
    .hRes      (hRes),
    .vRes      (vRes),
    .divLast   (divLast),
    .vZero     (vZero),
    .idxLast   (idxLast),
    .outByte   (outByte),
    .outIdx    (idxW)
  );

  assign outIdx = 5'(idxW);

endmodule

// File: rtl/avi_frame_chk.sv
module avi_frame_chk (
  input logic       clk,
  input logic       rstN,
  input logic       outReady,
  input logic [7:0] outByte,
  input logic [4:0] outIdx,
  input logic       outValid,
  input logic       outDone
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outByte) && $stable(outIdx));

  p_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outIdx != 5'd16 |=> outValid && outIdx == $past(outIdx) + 5'd1);

  p_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outIdx == 5'd0);

  p_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outIdx <= 5'd16);

  p_done_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outIdx == 5'd16 |=> outDone && !outValid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outDone) |-> $past(outValid) && $past(outReady) && $past(outIdx) == 5'd16);

  p_head_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIdx == 5'd0 |-> outByte == 8'h82);

  p_colour_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIdx == 5'd5 |-> $countones(outByte[7:6]) == 1);

endmodule

bind avi_frame_gen avi_frame_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .outReady (outReady),
  .outByte  (outByte),
  .outIdx   (outIdx),
  .outValid (outValid),
  .outDone  (outDone)
);

// File: tb/avi_frame_gen_tb_top.sv
module avi_frame_gen_tb_top;

  localparam int CW = 20;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] pixClkKhz = '0;
  logic [DW-1:0] hRes = '0;
  logic [DW-1:0] vRes = '0;
  logic          outReady = 1'b0;
  logic [7:0]    outByte;
  logic [4:0]    outIdx;
  logic          outValid;
  logic          outDone;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  avi_frame_gen dut_i (
    .clk(clk), .rstN(rstN), .start(start), .pixClkKhz(pixClkKhz),
    .hRes(hRes), .vRes(vRes), .outReady(outReady), .outByte(outByte),
    .outIdx(outIdx), .outValid(outValid), .outDone(outDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic lfsrStep();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // mode 0: always ready, 1: random stalls, 2: random stalls plus mid-packet start and input changes
  task automatic runPkt(input int pc, input int h, input int v, input int mode);
    int exp[17];
    int colour, aspect, total, got, guard, sum;
    bit doneSeen;
    for (int i = 0; i < 17; i++) exp[i] = 0;
    exp[0] = 'h82; exp[1] = 'h02; exp[2] = 'h0D; exp[4] = 'h12; exp[6] = 'h88;
    colour = (pc <= 27000) ? 'h40 : 'h80;
    if (v == 0) aspect = 'h28;
    else aspect = (((h * 100) / v) < 156) ? 'h18 : 'h28;
    exp[5] = colour | aspect;
    total = 0;
    for (int i = 0; i < 17; i++) total += exp[i];
    exp[3] = (256 - (total % 256)) % 256;

    @(negedge clk);
    pixClkKhz = CW'(pc); hRes = DW'(h); vRes = DW'(v); start = 1'b1;
    outReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (mode == 2) begin
      pixClkKhz = CW'(pc ^ 'h8_0000); hRes = DW'(h ^ 'h7FF); vRes = DW'(v ^ 'h3);
    end
    got = 0; guard = 0; sum = 0; doneSeen = 0;
    while (!doneSeen && guard < 600) begin
      start = 1'b0;
      if (outDone) begin
        doneSeen = 1;
        check(got == 17, "R9 done after last byte", got, 17);
        check(!outValid, "R9 valid low with done", outValid, 0);
        check((sum % 256) == 0, "R6 packet sum", sum % 256, 0);
      end else if (outValid) begin
        check(int'(outIdx) == got, "R7 index order", outIdx, got);
        if (got < 17) begin
          if (got == 3)
            check(int'(outByte) == exp[3], "R6 checksum byte", outByte, exp[3]);
          else if (got == 5) begin
            check(int'(outByte[7:6]) == colour / 64, "R3 colorimetry", outByte[7:6], colour / 64);
            if (v == 0)
              check(int'(outByte & 8'h38) == 'h28, "R5 zero height aspect", outByte & 8'h38, 'h28);
            else
              check(int'(outByte & 8'h38) == aspect, "R4 aspect code", outByte & 8'h38, aspect);
          end else
            check(int'(outByte) == exp[got], "R2 fixed byte", outByte, exp[got]);
        end
        outReady = (mode == 0) ? 1'b1 : lfsrStep();
        if (mode == 2 && (got == 4 || got == 11)) start = 1'b1;
        if (outReady) begin
          sum += int'(outByte);
          got++;
        end
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    outReady = 1'b0;
    check(doneSeen, "R9 packet completes", doneSeen, 1);
    check(!outDone, "R9 done one cycle", outDone, 0);
    repeat (3) @(negedge clk);
    check(!outValid && !outDone, "R10 no second packet", outValid, 0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pcs[4];
    int hs[12];
    int vs[11];
    int n;
    pcs = '{0, 27000, 27001, 148500};
    hs  = '{1, 4, 5, 39, 155, 156, 640, 720, 1024, 1280, 1920, 4095};
    vs  = '{0, 1, 3, 9, 25, 100, 480, 576, 768, 1080, 4095};
    repeat (4) @(negedge clk);
    check(!outValid && !outDone, "R1 reset outputs", {outValid, outDone}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!outValid && !outDone, "R1 idle after reset", {outValid, outDone}, 0);
    // exact ratio boundary: 3900/25 = 156, 15500/100 = 155
    runPkt(27000, 39, 25, 0);
    runPkt(27001, 155, 100, 1);
    runPkt(148500, 1920, 0, 2);
    n = 0;
    foreach (pcs[a]) foreach (hs[b]) foreach (vs[c]) begin
      runPkt(pcs[a], hs[b], vs[c], n % 3);
      n++;
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule